// File: doc/BRIEF.md
# Sequential Multi-Bit Shift-and-Add Multiplier

This block multiplies two unsigned operands over several clock cycles. A one-cycle pulse on the start input captures both operands and clears the product register. On each following cycle the unit takes the next K low-order bits of the multiplier operand A and multiplies them by B. B has been shifted up to the weight of those bits. The block adds that partial product into the product register. When every slice of A has been consumed, the done flag rises and the full-width product stays on the output.

The parameter K sets how many bits of A are retired per cycle. With K = 1 the datapath is a single adder fed by an AND-gated copy of B, and the latency equals the width of A. Larger K shortens the latency to ceil(A_W / K) cycles, at the cost of a wider partial-product generator. That generator is built either as a sum of gated rows or as a native multiply, chosen by a parameter. A new start pulse always wins: it abandons any operation in flight and begins again with the operands present on that cycle.

Top module: `slice_mul_seq`

## Requirements
- R1: While reset is asserted and after its release without a start, done_o is 0 and prod_o is 0.
- R2: On the cycle after start_i is sampled high, prod_o reads 0 and done_o reads 0.
- R3: done_o first reads 1 exactly ceil(A_W/K) + 1 rising edges after the edge at which start_i was sampled high, with no other start between them. With the defaults A_W=14, K=4 that is 4 accumulation cycles.
- R4: While done_o is 1, prod_o equals the unsigned product a_i*b_i of the operands captured by the most recent start, at the full A_W+B_W width.
- R5: Once done_o is 1 it stays 1, and prod_o stays unchanged, until start_i is sampled high again. Changes on a_i and b_i while start_i is low have no effect on prod_o or done_o.
- R6: A start sampled while an operation is in progress discards that operation. Latency and result then follow R3 and R4 for the new operands, including starts on two consecutive cycles.
- R7: A start sampled while done_o is 1 makes done_o read 0 on the next cycle and begins a new operation.
- R8: While an operation is in progress and no start arrives, prod_o never decreases from one cycle to the next.
- R9: When A_W is not a multiple of K, the top slice of A is zero-filled. Operands with their most significant bits set still produce the exact product in ceil(A_W/K) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture a_i and b_i and begin a multiplication |
| a_i | input | A_W | Multiplier operand, consumed K bits per cycle from the LSB |
| b_i | input | B_W | Multiplicand operand |
| prod_o | output | A_W+B_W | Product register (running partial sum while busy) |
| done_o | output | 1 | High from completion until the next start |

## Verification
Fixed corner operands are tried first: zero times anything, all-ones times all-ones, and one times B and A times one. Together these separate a dropped carry, a wrong slice weight and a swapped operand role. Patterns with only the top bits of A set, where the last slice is only partly populated, expose a mishandled zero-filled slice or a step count that is off by one. A long stream of pseudo-random operand pairs then runs, with the operand inputs toggling while idle and busy. Restarts after one cycle, back-to-back starts and starts issued while done is high separate correct abandonment of an operation from a stale accumulator or a stale step count.

// File: rtl/slice_mul_pkg.sv
package slice_mul_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_DONE = 2'd2
   } phase_e;

   // partial-product generator variants
   localparam int PP_ROWS   = 0;
   localparam int PP_NATIVE = 1;

   function automatic int steps_for(input int a_w, input int k);
      return (a_w + k - 1) / k;
   endfunction

endpackage

// File: rtl/slice_mul_ctrl.sv
module slice_mul_ctrl
   import slice_mul_pkg::*;
#(
   parameter int STEPS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic run,
   output logic fin
);

   localparam int CNT_W = $clog2(STEPS + 1);

   phase_e            ph_q;
   logic [CNT_W-1:0]  left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         left_q <= '0;
      end else if (start) begin
         ph_q   <= PH_RUN;
         left_q <= CNT_W'(STEPS);
      end else if (ph_q == PH_RUN) begin
         left_q <= left_q - 1'b1;
         if (left_q == CNT_W'(1)) begin
            ph_q <= PH_DONE;
         end
      end
   end

   assign run = (ph_q == PH_RUN);
   assign fin = (ph_q == PH_DONE);

endmodule

// File: rtl/slice_mul_opshift.sv
module slice_mul_opshift #(
   parameter int A_W   = 14,
   parameter int B_W   = 12,
   parameter int K     = 4,
   parameter int A_PAD = 16,
   parameter int P_W   = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   input  logic [A_W-1:0]   a_in,
   input  logic [B_W-1:0]   b_in,
   output logic [K-1:0]     digit,
   output logic [P_W-1:0]   mcand
);

   logic [A_PAD-1:0] a_q;
   logic [P_W-1:0]   b_q;

   // A walks down by K, B walks up by K: the slice and its weight stay aligned
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (load) begin
         a_q <= A_PAD'(a_in);
         b_q <= P_W'(b_in);
      end else if (adv) begin
         a_q <= a_q >> K;
         b_q <= b_q << K;
      end
   end

   assign digit = a_q[K-1:0];
   assign mcand = b_q;

endmodule

// File: rtl/slice_mul_pp.sv
module slice_mul_pp
   import slice_mul_pkg::*;
#(
   parameter int P_W   = 26,
   parameter int K     = 4,
   parameter int STYLE = PP_ROWS
) (
   input  logic [P_W-1:0] mcand,
   input  logic [K-1:0]   digit,
   output logic [P_W-1:0] pp
);

   generate
      if (K == 1) begin : g_gate
         assign pp = digit[0] ? mcand : '0;
      end else if (STYLE == PP_NATIVE) begin : g_native
         assign pp = mcand * P_W'(digit);
      end else begin : g_rows
         logic [P_W-1:0] row [K];
         for (genvar r = 0; r < K; r++) begin : g_row
            assign row[r] = digit[r] ? (mcand << r) : '0;
         end
         always_comb begin
            pp = '0;
            for (int r = 0; r < K; r++) begin
               pp = pp + row[r];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/slice_mul_seq.sv
module slice_mul_seq
   import slice_mul_pkg::*;
#(
   parameter int A_W      = 14,
   parameter int B_W      = 12,
   parameter int K        = 4,
   parameter int PP_STYLE = PP_ROWS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [A_W-1:0]       a_i,
   input  logic [B_W-1:0]       b_i,
   output logic [A_W+B_W-1:0]   prod_o,
   output logic                 done_o
);

   localparam int STEPS = steps_for(A_W, K);
   localparam int A_PAD = STEPS * K;
   localparam int P_W   = A_W + B_W;

   generate
      if (A_W < 1 || B_W < 1) begin : g_bad_width
         $error("slice_mul_seq: operand widths must be at least 1");
      end
      if (K < 1 || K > A_W) begin : g_bad_k
         $error("slice_mul_seq: K must lie between 1 and A_W");
      end
      if (PP_STYLE != PP_ROWS && PP_STYLE != PP_NATIVE) begin : g_bad_style
         $error("slice_mul_seq: unknown partial-product style");
      end
   endgenerate

   logic             busy;
   logic             fin;
   logic [K-1:0]     digit;
   logic [P_W-1:0]   mcand;
   logic [P_W-1:0]   pp;
   logic [P_W-1:0]   prod_q;

   slice_mul_ctrl #(
      .STEPS (STEPS)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_i),
      .run   (busy),
      .fin   (fin)
   );

   slice_mul_opshift #(
      .A_W   (A_W),
      .B_W   (B_W),
      .K     (K),
      .A_PAD (A_PAD),
      .P_W   (P_W)
   ) u_ops (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_i),
      .adv   (busy),
      .a_in  (a_i),
      .b_in  (b_i),
      .digit (digit),
      .mcand (mcand)
   );

   slice_mul_pp #(
      .P_W   (P_W),
      .K     (K),
      .STYLE (PP_STYLE)
   ) u_pp (
      .mcand (mcand),
      .digit (digit),
      .pp    (pp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
      end else if (start_i) begin
         prod_q <= '0;
      end else if (busy) begin
         prod_q <= prod_q + pp;
      end
   end

   assign prod_o = prod_q;
   assign done_o = fin;

endmodule

// File: rtl/slice_mul_seq_chk.sv
module slice_mul_seq_chk
   import slice_mul_pkg::*;
#(
   parameter int A_W = 14,
   parameter int B_W = 12,
   parameter int K   = 4,
   parameter int P_W = A_W + B_W
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start_i,
   input logic           done_o,
   input logic           busy,
   input logic [P_W-1:0] prod_o
);

   localparam int STEPS = steps_for(A_W, K);

   // edges since the last sampled start, saturating
   logic [15:0] el_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         el_q <= '0;
      end else if (start_i) begin
         el_q <= 16'd1;
      end else if (el_q != 16'd0 && el_q != 16'hffff) begin
         el_q <= el_q + 16'd1;
      end
   end

   p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (prod_o == '0 && !done_o));

   p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (el_q == 16'(STEPS + 1)));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(prod_o)));

   p_done_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && start_i) |=> !done_o);

   p_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start_i) |=> (prod_o >= $past(prod_o)));

endmodule

bind slice_mul_seq slice_mul_seq_chk #(
   .A_W (A_W),
   .B_W (B_W),
   .K   (K),
   .P_W (A_W + B_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .done_o  (done_o),
   .busy    (busy),
   .prod_o  (prod_o)
);

// File: tb/slice_mul_seq_tb_top.sv
`timescale 1ns/1ps
module slice_mul_seq_tb_top;

   localparam int A_W   = 14;
   localparam int B_W   = 12;
   localparam int K     = 4;
   localparam int P_W   = A_W + B_W;
   localparam int STEPS = (A_W + K - 1) / K;

   logic             clk   = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [A_W-1:0]   a     = '0;
   logic [B_W-1:0]   b     = '0;
   logic [P_W-1:0]   prod;
   logic             done;

   always #2 clk = ~clk;  // 250 MHz

   slice_mul_seq #(.A_W(A_W), .B_W(B_W), .K(K)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .a_i     (a),
      .b_i     (b),
      .prod_o  (prod),
      .done_o  (done)
   );

   int    vectors     = 0;
   int    miscompares = 0;
   bit    finished    = 1'b0;
   string scen        = "R1";

   // behavioural reference: remaining cycles, expected result, flags
   int              m_left  = 0;
   bit              m_done  = 1'b0;
   bit              m_fresh = 1'b0;
   longint unsigned m_exp   = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_left  = 0;
         m_done  = 1'b0;
         m_fresh = 1'b0;
      end else if (start) begin
         m_left  = STEPS;
         m_done  = 1'b0;
         m_fresh = 1'b1;
         m_exp   = longint'(a) * longint'(b);
      end else begin
         m_fresh = 1'b0;
         if (m_left > 0) begin
            m_left--;
            if (m_left == 0) m_done = 1'b1;
         end
      end
   end

   task automatic cmp(input string what, input longint unsigned act, input longint unsigned exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", scen, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (!finished) begin
         cmp("done_o (R3)", longint'(done), longint'(m_done));
         if (!rst_n || m_left == 0 && !m_done)
            cmp("idle prod_o (R1)", longint'(prod), 0);
         if (m_fresh)
            cmp("cleared prod_o (R2)", longint'(prod), 0);
         if (m_done)
            cmp("result prod_o (R4)", longint'(prod), m_exp);
      end
   end

   task automatic go(input logic [A_W-1:0] x, input logic [B_W-1:0] y);
      @(negedge clk);
      a = x; b = y; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         a = ~a;
         b = b + 12'h35b;
      end
   endtask

   task automatic op(input logic [A_W-1:0] x, input logic [B_W-1:0] y);
      go(x, y);
      idle(STEPS + 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'h1234_5678;
      scen = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(3);

      scen = "R4";
      op(14'h0000, 12'hfff);
      op(14'h3fff, 12'h000);
      op(14'h3fff, 12'hfff);
      op(14'h0001, 12'habc);
      op(14'h2d5a, 12'h001);
      op(14'h1555, 12'h aaa);
      for (int i = 0; i < A_W; i++) op(14'(1 << i), 12'h9c3);

      scen = "R9";
      op(14'h2000, 12'hfff);
      op(14'h3000, 12'h801);
      op(14'h3001, 12'hfff);

      scen = "R5";
      go(14'h1234, 12'h567);
      idle(STEPS + 20);

      scen = "R6";
      go(14'h3fff, 12'hfff);
      idle(1);
      op(14'h0123, 12'h456);
      @(negedge clk);
      a = 14'h2222; b = 12'h333; start = 1'b1;
      @(negedge clk);
      a = 14'h1f0f; b = 12'h0f1;
      @(negedge clk);
      start = 1'b0;
      idle(STEPS + 2);
      go(14'h0fff, 12'h777);
      idle(STEPS - 1);
      op(14'h0005, 12'h003);

      scen = "R7";
      op(14'h0abc, 12'hdef);
      go(14'h3333, 12'h444);
      idle(STEPS + 2);

      scen = "R8";
      for (int i = 0; i < 60; i++) begin
         seed = seed * 32'd1664525 + 32'd1013904223;
         op(seed[31:18], seed[13:2]);
      end

      idle(2);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule